// File: doc/BRIEF.md
# Streaming Envelope Peak Extractor

This block takes a frame of signed 16-bit samples, one per accepted cycle, and returns a frame of the same length that is zero everywhere except where the signal envelope has a local maximum. Inside the block there are three steps. The first takes the magnitude of each sample. The second smooths the magnitudes with a two-stage integrator-comb filter that does not change the sample rate, which gives the envelope. The third keeps an envelope value only if it is a local peak with respect to the samples on either side of it. After each step the result is brought back to a 16-bit word.

The block streams on both sides, and each side has its own valid, first and last markers. Filter history and peak history are cleared when a frame starts, so consecutive frames do not affect each other. The peak test needs one sample of look-ahead and no frame storage. Backpressure on the output freezes the whole pipeline. Gaps on the input change only the timing of the output, never its values.

Top module: `envpk_top`

## Requirements
- R1: The magnitude step maps a negative two's-complement input to its negation. The input -32768 maps to 32767. Non-negative inputs pass through unchanged.
- R2: The envelope at frame position n is the sum over k = 0..14 of w(k)·m(n−k), arithmetically shifted right by 6 and saturated to the signed 16-bit range. Here w(k) = k+1 for k < 8 and 15−k otherwise, and m is the magnitude, taken as 0 before the frame start. This is the response of two integrator-comb stages with a differential delay of 8. As a result, out_data is never negative.
- R3: An output sample equals the envelope value when that value is greater than or equal to its predecessor and strictly greater than its successor. Otherwise it is 0. On a flat top, only the final sample of the plateau is kept.
- R4: The first and last samples of every frame are always output as 0. A frame of a single sample gives one zero output with both out_first and out_last set.
- R5: A sample with in_first set starts from zero filter and comparison history. Nothing from an earlier frame reaches its output.
- R6: Each input frame produces an output frame with the same number of samples. out_first is set on the first output sample of the frame, and out_last on its final sample. Frames may follow each other with no idle cycle between them.
- R7: When the input is gap-free and out_ready is high, an input sample accepted at a clock edge is taken from the output four edges later. Its output register is loaded on the third edge.
- R8: When out_ready is low, in_ready is low, and out_valid, out_data, out_first and out_last hold their values. Stalls change no output value.
- R9: Idle cycles inside a frame (in_valid low) do not change the output values.
- R10: After reset, out_valid is 0. After the synchronized release, in_ready follows out_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Input sample accepted this cycle when high |
| in_data | input | 16 | Signed two's-complement input sample |
| in_first | input | 1 | Marks the first sample of a frame |
| in_last | input | 1 | Marks the last sample of a frame |
| out_valid | output | 1 | Output sample present |
| out_ready | input | 1 | Downstream can take a sample; low stalls the whole pipeline |
| out_data | output | 16 | Peak value at this position, or 0 |
| out_first | output | 1 | First sample of an output frame |
| out_last | output | 1 | Last sample of an output frame |

## Verification
The hardest case to reach from the ports is the peak stage holding the last sample of one frame while the first sample of the next frame arrives in the same cycle. The held sample has to be emitted as a zero while the new sample replaces it with cleared history. A single-sample frame, where the held sample is both first and last, is harder still. The stimulus reaches these cases with back-to-back frames of 50, 7 and 1 samples and no idle cycle between them. A separate pair of frames, a loud one followed by a silent one, shows any filter history that carries over as a spurious nonzero peak in the silent frame. Irregular gaps and stall patterns are overlaid on random data so that the freeze paths are exercised while frame boundaries pass through.

// File: rtl/envpk_pkg.sv
package envpk_pkg;

  localparam int unsigned SAMPLE_W = 16;

  // Sideband that travels with each sample through the pipeline
  typedef struct packed {
    logic vld;
    logic sof;
    logic eof;
  } envpk_ctl_t;

  localparam envpk_ctl_t CTL_IDLE = '{vld: 1'b0, sof: 1'b0, eof: 1'b0};

endpackage

// File: rtl/envpk_rect.sv
module envpk_rect
  import envpk_pkg::*;
#(
  parameter int unsigned W = SAMPLE_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  envpk_ctl_t ctl_i,
  input  logic [W-1:0] x_i,
  output envpk_ctl_t ctl_o,
  output logic [W-1:0] mag_o
);

  localparam logic [W-1:0] NEG_FULL = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] POS_FULL = {1'b0, {(W-1){1'b1}}};

  envpk_ctl_t   ctl_q;
  logic [W-1:0] mag_q, mag_d;
  logic         load;

  // Magnitude with saturation of the single unrepresentable value
  always_comb begin
    if (!x_i[W-1])          mag_d = x_i;
    else if (x_i == NEG_FULL) mag_d = POS_FULL;
    else                    mag_d = (~x_i) + 1'b1;
    load = en && ctl_i.vld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= CTL_IDLE;
      mag_q <= '0;
    end else begin
      if (en)   ctl_q <= ctl_i;
      if (load) mag_q <= mag_d;
    end
  end

  assign ctl_o = ctl_q;
  assign mag_o = mag_q;

endmodule

// File: rtl/envpk_cic.sv
module envpk_cic
  import envpk_pkg::*;
#(
  parameter int unsigned W_IN   = SAMPLE_W,
  parameter int unsigned W_OUT  = SAMPLE_W,
  parameter int unsigned STAGES = 2,
  parameter int unsigned DELAY  = 8,
  parameter int unsigned SHIFT  = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  envpk_ctl_t      ctl_i,
  input  logic [W_IN-1:0] x_i,
  output envpk_ctl_t      ctl_o,
  output logic [W_OUT-1:0] y_o
);

  // Growth of STAGES*log2(DELAY) bits plus a sign bit keeps wrap-free results
  localparam int unsigned W_ACC = W_IN + STAGES * $clog2(DELAY) + 1;
  localparam logic signed [W_ACC-1:0] SAT_HI =
    {{(W_ACC-W_OUT+1){1'b0}}, {(W_OUT-1){1'b1}}};
  localparam logic signed [W_ACC-1:0] SAT_LO =
    {{(W_ACC-W_OUT+1){1'b1}}, {(W_OUT-1){1'b0}}};

  logic signed [W_ACC-1:0] chain_i [STAGES+1];
  logic signed [W_ACC-1:0] chain_c [STAGES+1];
  logic signed [W_ACC-1:0] scaled;
  logic [W_OUT-1:0]        y_d, y_q;
  envpk_ctl_t              ctl_q;
  logic                    clr, load;

  assign clr  = ctl_i.sof;
  assign load = en && ctl_i.vld;

  assign chain_i[0] = W_ACC'({1'b0, x_i});
  assign chain_c[0] = chain_i[STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic signed [W_ACC-1:0] acc_q, acc_d;
    logic signed [W_ACC-1:0] dly_q [DELAY];
    logic signed [W_ACC-1:0] dly_d [DELAY];

    // Integrator: history is taken as zero on a frame start
    assign acc_d          = (clr ? '0 : acc_q) + chain_i[s];
    assign chain_i[s+1]   = acc_d;
    // Comb: difference against the value DELAY samples back
    assign chain_c[s+1]   = chain_c[s] - (clr ? '0 : dly_q[DELAY-1]);

    always_comb begin
      dly_d[0] = chain_c[s];
      for (int k = 1; k < DELAY; k++) begin
        dly_d[k] = clr ? '0 : dly_q[k-1];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc_q <= '0;
        for (int k = 0; k < DELAY; k++) dly_q[k] <= '0;
      end else if (load) begin
        acc_q <= acc_d;
        for (int k = 0; k < DELAY; k++) dly_q[k] <= dly_d[k];
      end
    end
  end

  // Scale and clamp back to the output word
  always_comb begin
    scaled = chain_c[STAGES] >>> SHIFT;
    if (scaled > SAT_HI)      y_d = SAT_HI[W_OUT-1:0];
    else if (scaled < SAT_LO) y_d = SAT_LO[W_OUT-1:0];
    else                      y_d = scaled[W_OUT-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= CTL_IDLE;
      y_q   <= '0;
    end else begin
      if (en)   ctl_q <= ctl_i;
      if (load) y_q   <= y_d;
    end
  end

  assign ctl_o = ctl_q;
  assign y_o   = y_q;

endmodule

// File: rtl/envpk_peak.sv
module envpk_peak
  import envpk_pkg::*;
#(
  parameter int unsigned W = SAMPLE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  envpk_ctl_t   ctl_i,
  input  logic [W-1:0] env_i,
  output envpk_ctl_t   ctl_o,
  output logic [W-1:0] pk_o
);

  envpk_ctl_t   mid_ctl_q, mid_ctl_d, out_ctl_q, out_ctl_d;
  logic [W-1:0] mid_q, mid_d, prv_q, prv_d, out_q, out_d;
  logic         emit, rise_ok, fall_ok, is_peak;

  always_comb begin
    // The held sample leaves once its successor arrives or it closes its frame
    emit    = mid_ctl_q.vld && (ctl_i.vld || mid_ctl_q.eof);
    rise_ok = $signed(mid_q) >= $signed(prv_q);
    fall_ok = $signed(mid_q) >  $signed(env_i);
    is_peak = mid_ctl_q.vld && ctl_i.vld && !ctl_i.sof &&
              !mid_ctl_q.sof && !mid_ctl_q.eof && rise_ok && fall_ok;

    out_ctl_d.vld = emit;
    out_ctl_d.sof = emit && mid_ctl_q.sof;
    out_ctl_d.eof = emit && mid_ctl_q.eof;
    out_d         = is_peak ? mid_q : '0;

    mid_ctl_d = mid_ctl_q;
    mid_d     = mid_q;
    prv_d     = prv_q;
    if (ctl_i.vld) begin
      mid_ctl_d = ctl_i;
      mid_d     = env_i;
      prv_d     = ctl_i.sof ? '0 : mid_q;
    end else if (emit) begin
      mid_ctl_d = CTL_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mid_ctl_q <= CTL_IDLE;
      out_ctl_q <= CTL_IDLE;
      mid_q     <= '0;
      prv_q     <= '0;
      out_q     <= '0;
    end else if (en) begin
      mid_ctl_q <= mid_ctl_d;
      out_ctl_q <= out_ctl_d;
      mid_q     <= mid_d;
      prv_q     <= prv_d;
      out_q     <= out_d;
    end
  end

  assign ctl_o = out_ctl_q;
  assign pk_o  = out_q;

endmodule

// File: rtl/envpk_top.sv
module envpk_top
  import envpk_pkg::*;
#(
  parameter int unsigned DATA_W     = SAMPLE_W,
  parameter int unsigned CIC_STAGES = 2,
  parameter int unsigned CIC_DELAY  = 8,
  parameter int unsigned CIC_SHIFT  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_first,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_first,
  output logic              out_last
);

  logic [1:0]        rst_pipe_q;
  logic              rst_ok;
  logic              adv;
  envpk_ctl_t        in_ctl, rect_ctl, env_ctl, pk_ctl;
  logic [DATA_W-1:0] mag, env, pk;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_ok = rst_pipe_q[1];

  // One enable for every stage: the pipeline moves only when the sink takes
  assign adv      = out_ready && rst_ok;
  assign in_ready = adv;

  always_comb begin
    in_ctl.vld = in_valid;
    in_ctl.sof = in_valid && in_first;
    in_ctl.eof = in_valid && in_last;
  end

  envpk_rect #(.W(DATA_W)) u_rect (
    .clk   (clk),
    .rst_n (rst_ok),
    .en    (adv),
    .ctl_i (in_ctl),
    .x_i   (in_data),
    .ctl_o (rect_ctl),
    .mag_o (mag)
  );

  envpk_cic #(
    .W_IN   (DATA_W),
    .W_OUT  (DATA_W),
    .STAGES (CIC_STAGES),
    .DELAY  (CIC_DELAY),
    .SHIFT  (CIC_SHIFT)
  ) u_cic (
    .clk   (clk),
    .rst_n (rst_ok),
    .en    (adv),
    .ctl_i (rect_ctl),
    .x_i   (mag),
    .ctl_o (env_ctl),
    .y_o   (env)
  );

  envpk_peak #(.W(DATA_W)) u_peak (
    .clk   (clk),
    .rst_n (rst_ok),
    .en    (adv),
    .ctl_i (env_ctl),
    .env_i (env),
    .ctl_o (pk_ctl),
    .pk_o  (pk)
  );

  assign out_valid = pk_ctl.vld;
  assign out_first = pk_ctl.sof;
  assign out_last  = pk_ctl.eof;
  assign out_data  = pk;

endmodule

// File: rtl/envpk_chk.sv
module envpk_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         out_valid,
  input logic         out_ready,
  input logic         out_first,
  input logic         out_last,
  input logic [W-1:0] out_data
);

  logic take, prev_nz_q, open_q;

  assign take = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_nz_q <= 1'b0;
      open_q    <= 1'b0;
    end else if (take) begin
      prev_nz_q <= (out_data != '0);
      open_q    <= !out_last;
    end
  end

  // R8: a stalled output sample stays exactly as presented
  p_hold_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) &&
                                $stable(out_first) && $stable(out_last));

  // R4: frame edges are never peaks
  p_edge_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_first || out_last) |-> out_data == '0);

  // R3: a kept peak is always followed by a zero in the same frame
  p_sparse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take && prev_nz_q |-> out_data == '0);

  // R2: the envelope of magnitudes cannot be negative
  p_nonneg_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !out_data[W-1]);

  // R6: after a frame closes, the next sample opens a new one
  p_frame_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take && !open_q |-> out_first);

  // R6: a frame start is only seen outside an open frame
  p_no_nested_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take && open_q |-> !out_first);

endmodule

bind envpk_top envpk_chk #(.W(DATA_W)) u_envpk_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_first (out_first),
  .out_last  (out_last),
  .out_data  (out_data)
);

// File: tb/envpk_top_bench.sv
module envpk_top_bench;

  localparam int MAXN = 3200;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, in_first, in_last;
  logic [15:0] in_data;
  logic        out_valid, out_ready, out_first, out_last;
  logic [15:0] out_data;

  always #4 clk = ~clk;

  envpk_top u_envpk_top (
    .clk (clk), .rst_n (rst_n),
    .in_valid (in_valid), .in_ready (in_ready), .in_data (in_data),
    .in_first (in_first), .in_last (in_last),
    .out_valid (out_valid), .out_ready (out_ready), .out_data (out_data),
    .out_first (out_first), .out_last (out_last)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  int total, cap_cnt, in_cnt, gap_mode, stall_mode, stall_viol, seed;
  logic signed [15:0] stim [MAXN];
  bit   s_first [MAXN], s_last [MAXN];
  int   expv [MAXN];
  int   cap_data [MAXN], in_cyc [MAXN], out_cyc [MAXN];
  bit   cap_f [MAXN], cap_l [MAXN];

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor samples away from the rising edge
  always @(negedge clk) begin
    #2;
    if (rst_n && out_valid && out_ready && cap_cnt < MAXN) begin
      cap_data[cap_cnt] = out_data;
      cap_f[cap_cnt]    = out_first;
      cap_l[cap_cnt]    = out_last;
      out_cyc[cap_cnt]  = cyc;
      cap_cnt++;
    end
    if (rst_n && in_valid && in_ready && in_cnt < MAXN) begin
      in_cyc[in_cnt] = cyc;
      in_cnt++;
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int mag_of(int v);
    if (v < 0) return (v == -32768) ? 32767 : -v;
    return v;
  endfunction

  // Independent model: triangular 15-tap weighting, shift 6, peak rule
  task automatic build_exp();
    int env [MAXN];
    int fs = 0;
    for (int i = 0; i < total; i++) begin
      int acc = 0;
      if (s_first[i]) fs = i;
      for (int k = 0; k < 15; k++) begin
        if (i - k >= fs) acc += ((k < 8) ? k + 1 : 15 - k) * mag_of(int'(stim[i-k]));
      end
      env[i] = acc / 64;
      if (env[i] > 32767) env[i] = 32767;
    end
    for (int i = 0; i < total; i++) begin
      if (!s_first[i] && !s_last[i] && env[i] >= env[i-1] && env[i] > env[i+1])
        expv[i] = env[i];
      else
        expv[i] = 0;
    end
  endtask

  function automatic bit rdy_pat(int k);
    return (stall_mode == 0) ? 1'b1 : ((k % 5) < 3);
  endfunction

  function automatic bit vld_pat(int k);
    return (gap_mode == 0) ? 1'b1 : ((k % 3) != 1);
  endfunction

  task automatic run_stream();
    int idx = 0, k = 0, guard = 0;
    cap_cnt = 0; in_cnt = 0; stall_viol = 0;
    while (idx < total) begin
      @(negedge clk);
      out_ready = rdy_pat(k);
      in_valid  = vld_pat(k);
      in_data   = stim[idx];
      in_first  = s_first[idx];
      in_last   = s_last[idx];
      k++;
      #1;
      if (!out_ready && in_ready) stall_viol++;
      if (in_valid && in_ready) idx++;
    end
    @(negedge clk);
    in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
    while (cap_cnt < total && guard < 20000) begin
      @(negedge clk);
      out_ready = rdy_pat(k);
      k++; guard++;
    end
    @(negedge clk);
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic compare_all(string req);
    check(cap_cnt == total, req, "output sample count", cap_cnt, total);
    for (int i = 0; i < total && i < cap_cnt; i++) begin
      check(cap_data[i] == expv[i], req, $sformatf("data[%0d]", i), cap_data[i], expv[i]);
      check(cap_f[i] == s_first[i], req, $sformatf("first[%0d]", i), cap_f[i], s_first[i]);
      check(cap_l[i] == s_last[i],  req, $sformatf("last[%0d]", i),  cap_l[i],  s_last[i]);
    end
  endtask

  task automatic frame_flags(int start, int len);
    for (int i = start; i < start + len; i++) begin
      s_first[i] = (i == start);
      s_last[i]  = (i == start + len - 1);
    end
  endtask

  function automatic logic signed [15:0] rnd();
    seed = seed * 1103515245 + 12345;
    return 16'(seed >>> 8);
  endfunction

  function automatic int count_nz(int a, int b);
    int n = 0;
    for (int i = a; i < b; i++) if (cap_data[i] != 0) n++;
    return n;
  endfunction

  task automatic t_reset();
    check(out_valid == 1'b0, "R10", "out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R10", "in_ready after release", in_ready, 1);
  endtask

  task automatic t_impulse();
    bit lat_ok = 1'b1;
    total = 40; gap_mode = 0; stall_mode = 0;
    for (int i = 0; i < total; i++) stim[i] = 16'sd0;
    stim[5] = 16'sd6400;
    frame_flags(0, total);
    build_exp(); run_stream(); compare_all("R2");
    check(cap_data[12] == 800, "R2", "impulse envelope apex", cap_data[12], 800);
    check(count_nz(0, total) == 1, "R3", "single peak for impulse", count_nz(0, total), 1);
    for (int i = 0; i < total; i++) if (out_cyc[i] - in_cyc[i] != 4) lat_ok = 1'b0;
    check(lat_ok, "R7", "fixed latency edge distance", out_cyc[0] - in_cyc[0], 4);
  endtask

  task automatic t_fullscale();
    total = 40; gap_mode = 0; stall_mode = 0;
    for (int i = 0; i < total; i++) stim[i] = (i < 20) ? -16'sd32768 : 16'sd0;
    frame_flags(0, total);
    build_exp(); run_stream(); compare_all("R1");
    check(cap_data[19] == 32767, "R1", "saturated magnitude at plateau end", cap_data[19], 32767);
    check(count_nz(0, total) == 1, "R3", "flat top gives one peak", count_nz(0, total), 1);
  endtask

  task automatic t_rising_end();
    total = 12; gap_mode = 0; stall_mode = 0;
    for (int i = 0; i < total; i++) stim[i] = 16'(1000 * (i + 1));
    frame_flags(0, total);
    build_exp(); run_stream(); compare_all("R4");
    check(cap_data[11] == 0, "R4", "last sample not a peak", cap_data[11], 0);
  endtask

  task automatic t_clear();
    total = 30; gap_mode = 0; stall_mode = 0;
    for (int i = 0; i < total; i++) stim[i] = (i < 10) ? 16'sd30000 : 16'sd0;
    frame_flags(0, 10); frame_flags(10, 20);
    build_exp(); run_stream(); compare_all("R5");
    check(count_nz(10, 30) == 0, "R5", "silent frame after loud frame", count_nz(10, 30), 0);
  endtask

  task automatic t_back_to_back();
    total = 58; gap_mode = 0; stall_mode = 0;
    for (int i = 0; i < total; i++) stim[i] = rnd();
    frame_flags(0, 50); frame_flags(50, 7); frame_flags(57, 1);
    build_exp(); run_stream(); compare_all("R6");
    check(cap_f[57] && cap_l[57] && cap_data[57] == 0, "R4",
          "single-sample frame", cap_data[57], 0);
  endtask

  task automatic t_gaps();
    total = 200; gap_mode = 1; stall_mode = 0;
    for (int i = 0; i < total; i++) stim[i] = rnd();
    frame_flags(0, 120); frame_flags(120, 80);
    build_exp(); run_stream(); compare_all("R9");
  endtask

  task automatic t_stall();
    total = 200; gap_mode = 1; stall_mode = 1;
    for (int i = 0; i < total; i++) stim[i] = rnd();
    frame_flags(0, 90); frame_flags(90, 110);
    build_exp(); run_stream(); compare_all("R8");
    check(stall_viol == 0, "R8", "in_ready while out_ready low", stall_viol, 0);
  endtask

  task automatic t_long_frame();
    total = 3000; gap_mode = 0; stall_mode = 0;
    for (int i = 0; i < total; i++) stim[i] = rnd();
    frame_flags(0, total);
    build_exp(); run_stream(); compare_all("R6");
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    seed = 32'h1234_5678;
    rst_n = 1'b0; out_ready = 1'b1; in_valid = 1'b0;
    in_first = 1'b0; in_last = 1'b0; in_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    t_reset();
    t_impulse();
    t_fullscale();
    t_rising_end();
    t_clear();
    t_back_to_back();
    t_gaps();
    t_stall();
    t_long_frame();
    summary();
    $finish;
  end

endmodule